// File: doc/BRIEF.md
# Single-Cycle Two-Format 16-bit Processor Core

This block is a small 16-bit processor core that completes one instruction per clock. It holds three registers: an address/operand register A, a data register D and a 15-bit program counter. Each cycle it receives the instruction fetched at the current program counter and the data word read at the current A. It returns the data to store, a store strobe, the data address and the next fetch address. The instruction memory and the data memory sit outside the core.

There are two instruction formats, and bit 15 selects between them. When bit 15 is clear, the word loads a 15-bit constant into A. When bit 15 is set, the word is a compute word. A compute word drives a six-control-bit ALU that takes D and either A or the memory read value. It names any mix of A, D and memory as destinations, and it may jump to the address held in A depending on the sign of the result. All register updates happen on one rising clock edge.

Top module: `cpu16_core`

## Requirements
- R1: `rst` is synchronous and is sampled at the rising edge. An edge with `rst` high clears A, D and the program counter to 0, and this overrides any jump. `mem_we_o` stays low while `rst` is high.
- R2: A word with bit 15 = 0 loads bits 14..0, zero-extended, into A. It does not store to memory, it leaves D unchanged and it does not jump.
- R3: A word is a compute word only when bits 15..13 = 111. In a compute word, bit 12 selects the second ALU operand: 1 selects `mem_rdata_i` and 0 selects A. The first operand is always D. A word with bit 15 = 1 and bits 14..13 not 11 is a no-op: nothing is written and the program counter advances by 1.
- R4: Bits 11..6 of a compute word are, from bit 11 downward: zero-x, invert-x, zero-y, invert-y, function (1 = add modulo 2^16, 0 = bitwise AND) and invert-output. The zero step is applied before the invert step on each operand.
- R5: Bit 5 of a compute word enables a write of the ALU result to A, bit 4 enables a write to D, and bit 3 raises `mem_we_o`. `mem_we_o` is high only for a compute word with bit 3 set.
- R6: `mem_wdata_o` is the ALU result of the current cycle. `mem_addr_o` is bits 14..0 of the current A. Both are combinational, in the same cycle.
- R7: Bits 2, 1 and 0 of a compute word test the ALU result for negative, zero and strictly positive. If any selected test holds, the next program counter is bits 14..0 of A as it was before this cycle's write.
- R8: When no jump is taken, the program counter advances by 1 and wraps modulo 2^15.
- R9: A hand-assembled program that counts a memory word down from 7 while it accumulates the values into a second word ends with the accumulator at 28 and the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Instruction word at the current fetch address |
| mem_rdata_i | input | 16 | Data memory word at `mem_addr_o` |
| mem_wdata_o | output | 16 | ALU result, the data to store |
| mem_we_o | output | 1 | Store strobe for the data memory |
| mem_addr_o | output | 15 | Data memory address (low bits of A) |
| fetch_addr_o | output | 15 | Program counter, the instruction fetch address |

## Verification
The assertions assume that `instr_i` and `mem_rdata_i` are settled, valid values at every rising edge where `rst` is low, and that `rst` is driven high from time zero. The bench changes both data inputs only on the falling edge, always from defined constants or from its own memory model, and it holds `rst` high across the first edges. For the stored-program run, the bench's memory returns the word at the current address before the edge. It commits a store only after that edge, so a read-modify-write word sees the old memory value, as the single-cycle timing implies.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int unsigned INSTR_W   = 16;
    localparam int unsigned FMT_BIT   = 15;
    localparam int unsigned OPSEL_BIT = 12;
    localparam int unsigned DST_A_BIT = 5;
    localparam int unsigned DST_D_BIT = 4;
    localparam int unsigned DST_M_BIT = 3;
    localparam int unsigned JMP_W     = 3;

    typedef struct packed {
        logic zx;
        logic nx;
        logic zy;
        logic ny;
        logic f;
        logic no;
    } alu_ctl_t;

    typedef struct packed {
        logic             is_ld;
        logic             is_cmp;
        logic             sel_mem;
        alu_ctl_t         alu;
        logic             wr_a;
        logic             wr_d;
        logic             wr_m;
        logic [JMP_W-1:0] jmask;
    } dec_t;

endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  alu_ctl_t     ctl_i,
    output logic [W-1:0] res_o,
    output logic         zr_o,
    output logic         ng_o
);

    logic [W-1:0] x_z, x_n, y_z, y_n, raw;

    always_comb begin
        x_z   = ctl_i.zx ? '0 : x_i;
        x_n   = ctl_i.nx ? ~x_z : x_z;
        y_z   = ctl_i.zy ? '0 : y_i;
        y_n   = ctl_i.ny ? ~y_z : y_z;
        raw   = ctl_i.f ? (x_n + y_n) : (x_n & y_n);
        res_o = ctl_i.no ? ~raw : raw;
        zr_o  = (res_o == '0);
        ng_o  = res_o[W-1];
    end

    // R4: both operands zeroed and added without inversion must give zero
    always_comb begin
        if (ctl_i.zx && ctl_i.zy && !ctl_i.nx && !ctl_i.ny && ctl_i.f && !ctl_i.no)
            a_r4_zero_sum: assert (res_o == '0) else $error("R4 zero sum broken");
    end

endmodule

// File: rtl/cpu16_decode.sv
module cpu16_decode
    import cpu16_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.is_ld   = ~instr_i[FMT_BIT];
        dec_o.is_cmp  = (instr_i[FMT_BIT:FMT_BIT-2] == 3'b111);
        if (dec_o.is_cmp) begin
            dec_o.sel_mem = instr_i[OPSEL_BIT];
            dec_o.alu     = alu_ctl_t'(instr_i[11:6]);
            dec_o.wr_a    = instr_i[DST_A_BIT];
            dec_o.wr_d    = instr_i[DST_D_BIT];
            dec_o.wr_m    = instr_i[DST_M_BIT];
            dec_o.jmask   = instr_i[JMP_W-1:0];
        end
    end

endmodule

// File: rtl/cpu16_branch.sv
module cpu16_branch
    import cpu16_pkg::*;
(
    input  logic [JMP_W-1:0] jmask_i,
    input  logic             zr_i,
    input  logic             ng_i,
    output logic             take_o
);

    logic [JMP_W-1:0] cond;

    always_comb begin
        cond   = {ng_i, zr_i, ~ng_i & ~zr_i};
        take_o = |(jmask_i & cond);
    end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [ADDR_W-1:0]   fetch_addr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [ADDR_W-1:0] pc;
    } state_t;

    state_t            state_d, state_q;
    dec_t              dec;
    logic [DATA_W-1:0] y_op, alu_res;
    logic              alu_zr, alu_ng, take;

    cpu16_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign y_op = dec.sel_mem ? mem_rdata_i : state_q.a;

    cpu16_alu #(.W(DATA_W)) u_alu (
        .x_i   (state_q.d),
        .y_i   (y_op),
        .ctl_i (dec.alu),
        .res_o (alu_res),
        .zr_o  (alu_zr),
        .ng_o  (alu_ng)
    );

    cpu16_branch u_branch (
        .jmask_i (dec.jmask),
        .zr_i    (alu_zr),
        .ng_i    (alu_ng),
        .take_o  (take)
    );

    always_comb begin
        state_d = state_q;
        if (dec.is_ld)
            state_d.a = DATA_W'(instr_i[ADDR_W-1:0]);
        if (dec.wr_a)
            state_d.a = alu_res;
        if (dec.wr_d)
            state_d.d = alu_res;
        state_d.pc = take ? state_q.a[ADDR_W-1:0] : state_q.pc + ADDR_W'(1);
        if (rst)
            state_d = '0;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign mem_wdata_o  = alu_res;
    assign mem_we_o     = dec.wr_m & ~rst;
    assign mem_addr_o   = state_q.a[ADDR_W-1:0];
    assign fetch_addr_o = state_q.pc;

    // R1: a reset edge leaves the program counter at zero
    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> state_q.pc == '0);

    // R2: a constant-load word puts its low bits in A
    a_r2_load_a: assert property (@(posedge clk) disable iff (rst)
        !instr_i[FMT_BIT] |=> state_q.a == DATA_W'($past(instr_i[ADDR_W-1:0])));

    // R2: a constant-load word leaves D alone
    a_r2_d_kept: assert property (@(posedge clk) disable iff (rst)
        !instr_i[FMT_BIT] |=> $stable(state_q.d));

    // R8: a constant-load word never jumps
    a_r8_seq_pc: assert property (@(posedge clk) disable iff (rst)
        !instr_i[FMT_BIT] |=> state_q.pc == $past(state_q.pc) + ADDR_W'(1));

    // R7: an always-jump word goes to the old A
    a_r7_always_jump: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15:13] == 3'b111 && instr_i[2:0] == 3'b111)
            |=> state_q.pc == $past(state_q.a[ADDR_W-1:0]));

    // R5: the store strobe needs a compute word with its memory bit set
    a_r5_store_gate: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (instr_i[15:13] == 3'b111) && instr_i[DST_M_BIT]);

endmodule

// File: tb/test_cpu16_core.sv
module test_cpu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'hEFC8;
    logic [15:0] rdata = 16'h0009;
    logic [15:0] wdata;
    logic        we;
    logic [14:0] addr;
    logic [14:0] pc;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] rom [32];
    logic [15:0] ram [32];

    // {instruction, expected ALU result} with D = 5, A = 3, memory word = 9
    localparam logic [31:0] VEC [19] = '{
        {16'hFA80, 16'h0000}, {16'hFFC0, 16'h0001}, {16'hFE80, 16'hFFFF},
        {16'hF300, 16'h0005}, {16'hFC00, 16'h0009}, {16'hF340, 16'hFFFA},
        {16'hFC40, 16'hFFF6}, {16'hF3C0, 16'hFFFB}, {16'hFCC0, 16'hFFF7},
        {16'hF7C0, 16'h0006}, {16'hFDC0, 16'h000A}, {16'hF380, 16'h0004},
        {16'hFC80, 16'h0008}, {16'hF080, 16'h000E}, {16'hF4C0, 16'hFFFC},
        {16'hF1C0, 16'h0004}, {16'hF000, 16'h0001}, {16'hF540, 16'h000D},
        {16'hE080, 16'h0008}
    };

    cpu16_core i_cpu16_core (
        .clk          (clk),
        .rst          (rst),
        .instr_i      (instr),
        .mem_rdata_i  (rdata),
        .mem_wdata_o  (wdata),
        .mem_we_o     (we),
        .mem_addr_o   (addr),
        .fetch_addr_o (pc)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] ins);
        @(negedge clk);
        instr = ins;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [14:0] pc_keep;
        // R1: reset state, store held off during reset
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pc in reset", 32'(pc), 32'h0);
        chk("R1 no store in reset", 32'(we), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        instr = 16'h0005;
        #1;
        drive(16'hEC10);                       // D=A
        chk("R8 pc after first word", 32'(pc), 32'h1);
        chk("R2 A loaded", 32'(addr), 32'h5);
        drive(16'h0003);                       // A=3
        // R3 R4 table: D=5, A=3, M=9
        for (int i = 0; i < 19; i++) begin
            drive(VEC[i][31:16]);
            chk("R3 R4 alu table", 32'(wdata), 32'(VEC[i][15:0]));
            chk("R5 no store without bit3", 32'(we), 32'h0);
        end
        chk("R6 address is A", 32'(addr), 32'h3);
        // R2 largest constant, R7 jump, R8 wrap
        drive(16'h7FFF);
        drive(16'hEA87);
        chk("R2 max constant", 32'(addr), 32'h7FFF);
        drive(16'h0000);
        chk("R7 jump to 7FFF", 32'(pc), 32'h7FFF);
        drive(16'h0014);
        chk("R8 pc wraps", 32'(pc), 32'h0);
        drive(16'hEDE7);                       // A=A+1;JMP
        chk("R4 A+1", 32'(wdata), 32'h15);
        drive(16'hE300);
        chk("R7 target is old A", 32'(pc), 32'h14);
        chk("R5 A written", 32'(addr), 32'h15);
        chk("R2 D kept", 32'(wdata), 32'h5);
        // zero result
        drive(16'hEA90);                       // D=0
        drive(16'h0010);
        drive(16'hE302);                       // JEQ
        drive(16'hE301);                       // JGT
        chk("R7 JEQ taken on zero", 32'(pc), 32'h10);
        drive(16'hEE90);                       // D=-1
        chk("R7 JGT not taken on zero", 32'(pc), 32'h11);
        drive(16'h0028);
        drive(16'hE304);                       // JLT
        drive(16'hE303);                       // JGE
        chk("R7 JLT taken on negative", 32'(pc), 32'h28);
        drive(16'hEFD0);                       // D=1
        chk("R7 JGE not taken on negative", 32'(pc), 32'h29);
        drive(16'h0032);
        drive(16'hE301);                       // JGT
        drive(16'hE306);                       // JLE
        chk("R7 JGT taken on positive", 32'(pc), 32'h32);
        drive(16'hEFC8);                       // M=1
        chk("R7 JLE not taken on positive", 32'(pc), 32'h33);
        chk("R5 store strobe", 32'(we), 32'h1);
        chk("R6 store data one", 32'(wdata), 32'h1);
        drive(16'hEA88);                       // M=0
        chk("R5 store strobe", 32'(we), 32'h1);
        chk("R6 store data zero", 32'(wdata), 32'h0);
        drive(16'h0003);
        drive(16'hEA90);                       // D=0
        drive(16'hEDF8);                       // AMD=A+1
        chk("R5 all dest store", 32'(we), 32'h1);
        chk("R5 all dest value", 32'(wdata), 32'h4);
        drive(16'h1234);
        chk("R5 A from all dest", 32'(addr), 32'h4);
        chk("R2 no store on load", 32'(we), 32'h0);
        drive(16'hE300);
        chk("R5 D from all dest", 32'(wdata), 32'h4);
        chk("R2 A after load", 32'(addr), 32'h1234);
        drive(16'hAFC8);                       // bits 14..13 = 01
        chk("R3 malformed word no store", 32'(we), 32'h0);
        pc_keep = pc;
        drive(16'hE300);
        chk("R3 malformed word advances pc", 32'(pc), 32'(pc_keep + 15'd1));
        chk("R3 malformed word keeps D", 32'(wdata), 32'h4);
        chk("R3 malformed word keeps A", 32'(addr), 32'h1234);
        // R1 reset beats a jump to A=1234
        @(negedge clk);
        rst = 1'b1;
        instr = 16'hEA87;
        #1;
        chk("R1 no store in reset", 32'(we), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        instr = 16'hE300;
        #1;
        chk("R1 reset beats jump", 32'(pc), 32'h0);
        chk("R1 D cleared", 32'(wdata), 32'h0);
        chk("R1 A cleared", 32'(addr), 32'h0);

        // R9 stored program: ram[3] = 7+6+...+1, ram[2] counts down
        rom[0]  = 16'h0007; rom[1]  = 16'hEC10; rom[2]  = 16'h0002; rom[3]  = 16'hE308;
        rom[4]  = 16'h0003; rom[5]  = 16'hEA88; rom[6]  = 16'h0002; rom[7]  = 16'hFC10;
        rom[8]  = 16'h0010; rom[9]  = 16'hE302; rom[10] = 16'h0003; rom[11] = 16'hF088;
        rom[12] = 16'h0002; rom[13] = 16'hFC88; rom[14] = 16'h0006; rom[15] = 16'hEA87;
        rom[16] = 16'h0010; rom[17] = 16'hEA87;
        for (int i = 18; i < 32; i++) rom[i] = 16'h0000;
        for (int i = 0; i < 32; i++) ram[i] = 16'hFFFF;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        begin
            logic        p_we;
            logic [4:0]  p_a;
            logic [15:0] p_d;
            p_we = 1'b0;
            p_a  = '0;
            p_d  = '0;
            for (int c = 0; c < 160; c++) begin
                if (c != 0) @(negedge clk);
                if (p_we) ram[p_a] = p_d;
                instr = rom[pc[4:0]];
                rdata = ram[addr[4:0]];
                #1;
                p_we = we;
                p_a  = addr[4:0];
                p_d  = wdata;
            end
            @(negedge clk);
            if (p_we) ram[p_a] = p_d;
        end
        chk("R9 accumulated sum", 32'(ram[3]), 32'd28);
        chk("R9 counter reached zero", 32'(ram[2]), 32'd0);
        chk("R9 parked at end loop", 32'(pc >= 15'd16 && pc <= 15'd17), 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule